// File: doc/BRIEF.md
# Polled-Semaphore Batch Transfer Engines

This block holds two cooperating engines that hand fixed-size batches of data words from a sending side to a receiving side through shared memory. Neither engine signals the other directly. The sender fills a buffer region and then sets a ready semaphore. The receiver finds that semaphore by polling, takes it back to zero, drains the buffer and then sets a done semaphore. The sender finds the done semaphore by polling in turn, and only then begins its next batch.

Each engine owns a simple memory request port. A request is held stable until the memory answers with a one-cycle acknowledge, which also carries the read data. The memory behind the two ports, and any sharing of it, sit outside the block. The semaphore addresses, the buffer base and the batch length are parameters. The idle time between two polls is an input, so the polling rate can be tuned to the load on the memory. Every word the receiver fetches is presented on a streaming output with a valid strobe.

Top module: `pc_handshake`

## Requirements
- R1: While reset is high, and in the first cycle after it, both request lines and `out_valid` are low.
- R2: Once an engine raises its request, it keeps request, write enable, address and write data unchanged until the cycle in which acknowledge is high.
- R3: Each sender batch begins with a write of 0 to the done-semaphore address (`STAT_ADDR`). It then writes `BATCH_LEN` words to the ascending addresses `BUF_BASE` through `BUF_BASE+BATCH_LEN-1`.
- R4: The sender writes the value 1 to the ready-semaphore address (`FLAG_ADDR`) only after every data write of the batch has been acknowledged.
- R5: After setting the ready semaphore, the sender polls `STAT_ADDR` with reads. It starts no new batch until one of those reads returns exactly 1.
- R6: The receiver polls `FLAG_ADDR` with reads, and only the value 1 counts as ready. On ready it writes 0 to `FLAG_ADDR` before it issues any buffer read.
- R7: After clearing the ready semaphore, the receiver reads `BUF_BASE` through `BUF_BASE+BATCH_LEN-1` in ascending order. Only after the last of these reads does it write 1 to `STAT_ADDR`.
- R8: Each buffer word the receiver reads appears on `out_data`, with `out_valid` high for one cycle, in the cycle after its acknowledge. Within each batch, the words match the sender's data writes in order.
- R9: After a poll that does not return 1, the polling engine keeps its request low for exactly `poll_gap`+1 cycles, using the `poll_gap` value seen in the acknowledge cycle, and then polls again.
- R10: While `run` is low, the sender issues no request once its current batch has been released. The receiver keeps polling regardless of `run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allows the sender to begin new batches |
| poll_gap | input | GAP_W | Idle cycles minus one between polls |
| prod_req | output | 1 | Sender memory request |
| prod_we | output | 1 | Sender write enable |
| prod_addr | output | ADDR_W | Sender address |
| prod_wdata | output | DATA_W | Sender write data |
| prod_ack | input | 1 | Sender request acknowledge |
| prod_rdata | input | DATA_W | Sender read data, valid with acknowledge |
| cons_req | output | 1 | Receiver memory request |
| cons_we | output | 1 | Receiver write enable |
| cons_addr | output | ADDR_W | Receiver address |
| cons_wdata | output | DATA_W | Receiver write data |
| cons_ack | input | 1 | Receiver request acknowledge |
| cons_rdata | input | DATA_W | Receiver read data, valid with acknowledge |
| out_valid | output | 1 | Delivered word strobe |
| out_data | output | DATA_W | Delivered word |

## Verification
A semaphore write from one engine and a poll of that same semaphore by the other engine can be acknowledged in the same cycle. This happens when the sender sets the ready semaphore while the receiver reads it, and again when the receiver sets the done semaphore while the sender reads it. The bench provokes these collisions with zero-latency acknowledges and a zero poll gap, and lets the read return the value held before the write. It then judges that the losing poll only delays the handshake by one poll interval, and that the delivered words and the semaphore ordering are unaffected.

// File: rtl/pc_pkg.sv
package pc_pkg;

    // Value a semaphore must hold to count as set
    localparam int unsigned SEM_SET = 1;

    typedef enum logic [2:0] {
        P_IDLE,
        P_CLR,
        P_DATA,
        P_FLAG,
        P_WAIT,
        P_POLL
    } prod_st_e;

    typedef enum logic [2:0] {
        C_WAIT,
        C_POLL,
        C_CLR,
        C_READ,
        C_STAT
    } cons_st_e;

    // Test-pattern word for a given batch number and word index
    function automatic logic [31:0] mix_word(input logic [15:0] b, input logic [15:0] i);
        logic [15:0] hi;
        logic [15:0] lo;
        hi = b ^ 16'hC3A5;
        lo = (b * 16'h0035) ^ i ^ 16'h7E01;
        return {hi, lo};
    endfunction

endpackage

// File: rtl/pc_gap_timer.sv
module pc_gap_timer #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [GAP_W-1:0] gap,
    output logic             zero
);
    logic [GAP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= gap;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pc_producer.sv
module pc_producer
    import pc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int BATCH_LEN = 4,
    parameter int BUF_BASE  = 16,
    parameter int FLAG_ADDR = 2,
    parameter int STAT_ADDR = 3,
    parameter int GAP_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [GAP_W-1:0]  poll_gap,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = (BATCH_LEN > 1) ? $clog2(BATCH_LEN) : 1;
    localparam logic [ADDR_W-1:0] BUF_A  = ADDR_W'(BUF_BASE);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [IDX_W-1:0]  LAST   = IDX_W'(BATCH_LEN - 1);

    prod_st_e         st;
    logic [IDX_W-1:0] idx;
    logic [15:0]      batch;
    logic             sem_hit;
    logic             tmr_load;
    logic             tmr_zero;
    logic [31:0]      word;

    assign sem_hit  = (rdata == DATA_W'(SEM_SET));
    assign tmr_load = ack && ((st == P_FLAG) || (st == P_POLL && !sem_hit));
    assign word     = mix_word(batch, 16'(idx));

    pc_gap_timer #(.GAP_W(GAP_W)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .gap  (poll_gap),
        .zero (tmr_zero)
    );

    always_comb begin
        req   = (st == P_CLR) || (st == P_DATA) || (st == P_FLAG) || (st == P_POLL);
        we    = (st != P_POLL);
        wdata = '0;
        case (st)
            P_CLR, P_POLL: addr = STAT_A;
            P_FLAG: begin
                addr  = FLAG_A;
                wdata = DATA_W'(SEM_SET);
            end
            default: begin
                addr  = BUF_A + ADDR_W'(idx);
                wdata = DATA_W'(word);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= P_IDLE;
            idx   <= '0;
            batch <= '0;
        end else begin
            case (st)
                P_IDLE: if (run) st <= P_CLR;
                P_CLR: if (ack) begin
                    st  <= P_DATA;
                    idx <= '0;
                end
                P_DATA: if (ack) begin
                    if (idx == LAST) st <= P_FLAG;
                    else idx <= idx + 1'b1;
                end
                P_FLAG: if (ack) st <= P_WAIT;
                P_WAIT: if (tmr_zero) st <= P_POLL;
                P_POLL: if (ack) begin
                    if (sem_hit) begin
                        batch <= batch + 1'b1;
                        st    <= run ? P_CLR : P_IDLE;
                    end else begin
                        st <= P_WAIT;
                    end
                end
                default: st <= P_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pc_consumer.sv
module pc_consumer
    import pc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int BATCH_LEN = 4,
    parameter int BUF_BASE  = 16,
    parameter int FLAG_ADDR = 2,
    parameter int STAT_ADDR = 3,
    parameter int GAP_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GAP_W-1:0]  poll_gap,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int IDX_W = (BATCH_LEN > 1) ? $clog2(BATCH_LEN) : 1;
    localparam logic [ADDR_W-1:0] BUF_A  = ADDR_W'(BUF_BASE);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [IDX_W-1:0]  LAST   = IDX_W'(BATCH_LEN - 1);

    cons_st_e         st;
    logic [IDX_W-1:0] idx;
    logic             sem_hit;
    logic             tmr_load;
    logic             tmr_zero;

    assign sem_hit  = (rdata == DATA_W'(SEM_SET));
    assign tmr_load = ack && ((st == C_STAT) || (st == C_POLL && !sem_hit));

    pc_gap_timer #(.GAP_W(GAP_W)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .gap  (poll_gap),
        .zero (tmr_zero)
    );

    always_comb begin
        req   = (st != C_WAIT);
        we    = (st == C_CLR) || (st == C_STAT);
        wdata = (st == C_STAT) ? DATA_W'(SEM_SET) : '0;
        case (st)
            C_POLL, C_CLR: addr = FLAG_A;
            C_STAT:        addr = STAT_A;
            default:       addr = BUF_A + ADDR_W'(idx);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= C_WAIT;
            idx       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            case (st)
                C_WAIT: if (tmr_zero) st <= C_POLL;
                C_POLL: if (ack) st <= sem_hit ? C_CLR : C_WAIT;
                C_CLR: if (ack) begin
                    st  <= C_READ;
                    idx <= '0;
                end
                C_READ: if (ack) begin
                    out_valid <= 1'b1;
                    out_data  <= rdata;
                    if (idx == LAST) st <= C_STAT;
                    else idx <= idx + 1'b1;
                end
                C_STAT: if (ack) st <= C_WAIT;
                default: st <= C_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/pc_handshake.sv
module pc_handshake #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int BATCH_LEN = 4,
    parameter int BUF_BASE  = 16,
    parameter int FLAG_ADDR = 2,
    parameter int STAT_ADDR = 3,
    parameter int GAP_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [GAP_W-1:0]  poll_gap,
    output logic              prod_req,
    output logic              prod_we,
    output logic [ADDR_W-1:0] prod_addr,
    output logic [DATA_W-1:0] prod_wdata,
    input  logic              prod_ack,
    input  logic [DATA_W-1:0] prod_rdata,
    output logic              cons_req,
    output logic              cons_we,
    output logic [ADDR_W-1:0] cons_addr,
    output logic [DATA_W-1:0] cons_wdata,
    input  logic              cons_ack,
    input  logic [DATA_W-1:0] cons_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    pc_producer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BATCH_LEN(BATCH_LEN), .BUF_BASE(BUF_BASE),
        .FLAG_ADDR(FLAG_ADDR), .STAT_ADDR(STAT_ADDR), .GAP_W(GAP_W)
    ) u_prod (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .poll_gap (poll_gap),
        .req      (prod_req),
        .we       (prod_we),
        .addr     (prod_addr),
        .wdata    (prod_wdata),
        .ack      (prod_ack),
        .rdata    (prod_rdata)
    );

    pc_consumer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BATCH_LEN(BATCH_LEN), .BUF_BASE(BUF_BASE),
        .FLAG_ADDR(FLAG_ADDR), .STAT_ADDR(STAT_ADDR), .GAP_W(GAP_W)
    ) u_cons (
        .clk       (clk),
        .rst       (rst),
        .poll_gap  (poll_gap),
        .req       (cons_req),
        .we        (cons_we),
        .addr      (cons_addr),
        .wdata     (cons_wdata),
        .ack       (cons_ack),
        .rdata     (cons_rdata),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/pc_handshake_chk.sv
module pc_handshake_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int BATCH_LEN = 4,
    parameter int BUF_BASE  = 16,
    parameter int FLAG_ADDR = 2,
    parameter int STAT_ADDR = 3,
    parameter int GAP_W     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic [GAP_W-1:0]  poll_gap,
    input logic              prod_req,
    input logic              prod_we,
    input logic [ADDR_W-1:0] prod_addr,
    input logic [DATA_W-1:0] prod_wdata,
    input logic              prod_ack,
    input logic [DATA_W-1:0] prod_rdata,
    input logic              cons_req,
    input logic              cons_we,
    input logic [ADDR_W-1:0] cons_addr,
    input logic [DATA_W-1:0] cons_wdata,
    input logic              cons_ack,
    input logic [DATA_W-1:0] cons_rdata,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam logic [ADDR_W:0]   BUF_LO = (ADDR_W + 1)'(BUF_BASE);
    localparam logic [ADDR_W:0]   BUF_HI = (ADDR_W + 1)'(BUF_BASE + BATCH_LEN);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [15:0]       LEN16  = 16'(BATCH_LEN);

    logic        p_buf;
    logic        c_buf;
    logic        p_done;
    logic        c_done;
    logic [15:0] p_cnt;
    logic [15:0] c_cnt;
    logic        c_clr;

    assign p_buf  = ({1'b0, prod_addr} >= BUF_LO) && ({1'b0, prod_addr} < BUF_HI);
    assign c_buf  = ({1'b0, cons_addr} >= BUF_LO) && ({1'b0, cons_addr} < BUF_HI);
    assign p_done = prod_req && prod_ack;
    assign c_done = cons_req && cons_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_cnt <= '0;
            c_cnt <= '0;
            c_clr <= 1'b0;
        end else begin
            if (p_done && prod_we && prod_addr == STAT_A) p_cnt <= '0;
            else if (p_done && prod_we && p_buf) p_cnt <= p_cnt + 1'b1;
            if (c_done && cons_we && cons_addr == FLAG_A) begin
                c_clr <= 1'b1;
                c_cnt <= '0;
            end else if (c_done && cons_we && cons_addr == STAT_A) begin
                c_clr <= 1'b0;
            end else if (c_done && !cons_we && c_buf) begin
                c_cnt <= c_cnt + 1'b1;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!prod_req && !cons_req && !out_valid));

    assert_prod_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (prod_req && !prod_ack) |=> (prod_req && $stable(prod_we) && $stable(prod_addr) && $stable(prod_wdata)));

    assert_cons_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cons_req && !cons_ack) |=> (cons_req && $stable(cons_we) && $stable(cons_addr) && $stable(cons_wdata)));

    assert_flag_after_data_R4: assert property (@(posedge clk) disable iff (rst)
        (p_done && prod_we && prod_addr == FLAG_A) |-> (p_cnt == LEN16));

    assert_clear_before_read_R6: assert property (@(posedge clk) disable iff (rst)
        (cons_req && !cons_we && c_buf) |-> c_clr);

    assert_status_after_reads_R7: assert property (@(posedge clk) disable iff (rst)
        (c_done && cons_we && cons_addr == STAT_A) |-> (c_cnt == LEN16));

    assert_out_follows_ack_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(c_done && !cons_we));
endmodule

bind pc_handshake pc_handshake_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BATCH_LEN(BATCH_LEN), .BUF_BASE(BUF_BASE),
    .FLAG_ADDR(FLAG_ADDR), .STAT_ADDR(STAT_ADDR), .GAP_W(GAP_W)
) u_chk (.*);

// File: tb/sim_pc_handshake.sv
module sim_pc_handshake;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int LEN = 4;
    localparam int BB  = 16;
    localparam int FA  = 2;
    localparam int SA  = 3;
    localparam int GW  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0;
    logic [GW-1:0] poll_gap = '0;
    logic          prod_req, prod_we, cons_req, cons_we, out_valid;
    logic [AW-1:0] prod_addr, cons_addr;
    logic [DW-1:0] prod_wdata, cons_wdata, out_data;
    logic          prod_ack = 1'b0;
    logic          cons_ack = 1'b0;
    logic [DW-1:0] prod_rdata = '0;
    logic [DW-1:0] cons_rdata = '0;

    pc_handshake #(
        .ADDR_W(AW), .DATA_W(DW), .BATCH_LEN(LEN), .BUF_BASE(BB),
        .FLAG_ADDR(FA), .STAT_ADDR(SA), .GAP_W(GW)
    ) u0 (.*);

    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural memory and reference state
    logic [DW-1:0] mem [256];
    logic [DW-1:0] exp_q [$];
    int  lat_max = 0;
    bit  p_busy = 0, c_busy = 0;
    int  p_wait = 0, c_wait = 0;
    logic [AW-1:0] p_a0, c_a0;
    logic [DW-1:0] p_d0, c_d0;
    bit  p_w0, c_w0;
    bit  p_released = 1, p_cleared = 0, c_seen = 0, c_cleared = 0;
    int  p_dcnt = 0, c_rd = 0, batches = 0, releases = 0, delivered = 0, c_polls = 0;
    bit  p_gap_on = 0, c_gap_on = 0;
    int  p_gap_cnt = 0, c_gap_cnt = 0, p_gap_exp = 0, c_gap_exp = 0;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
    end

    task automatic prod_event();
        if (prod_we) begin
            if (int'(prod_addr) == SA) begin
                chk(prod_wdata == 0, "R3 status clear value", prod_wdata, 0);
                chk(p_released, "R5 batch start before release", 0, 1);
                p_released = 0; p_cleared = 1; p_dcnt = 0;
            end else if (int'(prod_addr) == FA) begin
                chk(prod_wdata == 1, "R4 flag value", prod_wdata, 1);
                chk(p_dcnt == LEN, "R4 data writes before flag", p_dcnt, LEN);
                p_cleared = 0;
            end else if (int'(prod_addr) >= BB && int'(prod_addr) < BB + LEN) begin
                chk(p_cleared, "R3 status cleared before data", 0, 1);
                chk(int'(prod_addr) == BB + p_dcnt, "R3 data address", prod_addr, BB + p_dcnt);
                exp_q.push_back(prod_wdata);
                p_dcnt++;
            end else begin
                chk(0, "R3 producer write address", prod_addr, BB);
            end
            mem[prod_addr] = prod_wdata;
        end else begin
            chk(int'(prod_addr) == SA, "R5 producer poll address", prod_addr, SA);
            if (prod_rdata == 1) begin
                p_released = 1;
                releases++;
            end else begin
                p_gap_on = 1; p_gap_cnt = 0; p_gap_exp = int'(poll_gap) + 1;
            end
        end
    endtask

    task automatic cons_event();
        if (cons_we) begin
            if (int'(cons_addr) == FA) begin
                chk(cons_wdata == 0, "R6 flag clear value", cons_wdata, 0);
                chk(c_seen, "R6 clear only after flag seen", 0, 1);
                c_cleared = 1; c_rd = 0;
            end else if (int'(cons_addr) == SA) begin
                chk(cons_wdata == 1, "R7 status value", cons_wdata, 1);
                chk(c_rd == LEN, "R7 reads before status", c_rd, LEN);
                c_cleared = 0; c_seen = 0;
                batches++;
            end else begin
                chk(0, "R7 consumer write address", cons_addr, SA);
            end
            mem[cons_addr] = cons_wdata;
        end else begin
            if (int'(cons_addr) == FA) begin
                c_polls++;
                if (cons_rdata == 1) c_seen = 1;
                else begin
                    c_gap_on = 1; c_gap_cnt = 0; c_gap_exp = int'(poll_gap) + 1;
                end
            end else begin
                chk(c_cleared, "R6 buffer read after clear", 0, 1);
                chk(int'(cons_addr) == BB + c_rd, "R7 read address", cons_addr, BB + c_rd);
                c_rd++;
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            prod_ack = 0; cons_ack = 0; p_busy = 0; c_busy = 0;
        end else begin
            bit p_fire, c_fire;
            if (out_valid) begin
                delivered++;
                if (exp_q.size() == 0) chk(0, "R8 unexpected word", out_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R8 delivered word", out_data, e);
                end
            end
            if (p_gap_on) begin
                if (!prod_req) p_gap_cnt++;
                else begin
                    chk(p_gap_cnt == p_gap_exp, "R9 producer poll gap", p_gap_cnt, p_gap_exp);
                    p_gap_on = 0;
                end
            end
            if (c_gap_on) begin
                if (!cons_req) c_gap_cnt++;
                else begin
                    chk(c_gap_cnt == c_gap_exp, "R9 consumer poll gap", c_gap_cnt, c_gap_exp);
                    c_gap_on = 0;
                end
            end
            if (prod_ack) begin prod_ack = 0; p_busy = 0; end
            if (cons_ack) begin cons_ack = 0; c_busy = 0; end
            p_fire = 0; c_fire = 0;
            if (prod_req && !p_busy) begin
                p_busy = 1; p_wait = $urandom_range(lat_max, 0);
                p_a0 = prod_addr; p_w0 = prod_we; p_d0 = prod_wdata;
            end
            if (cons_req && !c_busy) begin
                c_busy = 1; c_wait = $urandom_range(lat_max, 0);
                c_a0 = cons_addr; c_w0 = cons_we; c_d0 = cons_wdata;
            end
            if (p_busy) begin
                if (p_wait == 0) p_fire = 1; else p_wait--;
            end
            if (c_busy) begin
                if (c_wait == 0) c_fire = 1; else c_wait--;
            end
            // reads sample memory before either write of this cycle lands
            if (p_fire) begin
                chk(prod_req && prod_addr == p_a0 && prod_we == p_w0 && prod_wdata == p_d0,
                    "R2 producer request held", prod_addr, p_a0);
                prod_ack = 1; prod_rdata = mem[prod_addr];
            end
            if (c_fire) begin
                chk(cons_req && cons_addr == c_a0 && cons_we == c_w0 && cons_wdata == c_d0,
                    "R2 consumer request held", cons_addr, c_a0);
                cons_ack = 1; cons_rdata = mem[cons_addr];
            end
            if (p_fire) prod_event();
            if (c_fire) cons_event();
        end
    end

    task automatic wait_batches(input int target);
        while (batches < target) @(posedge clk);
    endtask

    task automatic set_mode(input int g, input int l);
        @(posedge clk); #1;
        poll_gap = GW'(g);
        lat_max  = l;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!prod_req && !cons_req && !out_valid, "R1 quiet in reset",
            {prod_req, cons_req, out_valid}, 0);
        @(posedge clk); #1;
        rst = 0;
        @(negedge clk);
        chk(!prod_req && !cons_req && !out_valid, "R1 quiet after reset",
            {prod_req, cons_req, out_valid}, 0);
        @(posedge clk); #1;
        run = 1;

        // collisions: zero latency, zero gap
        wait_batches(3);
        set_mode(3, 3);
        wait_batches(6);
        set_mode(9, 1);
        wait_batches(9);

        // R10: sender stays quiet with run low
        begin
            int rel0, hi_cnt, polls0;
            @(posedge clk); #1;
            run = 0;
            rel0 = releases;
            while (releases == rel0) @(posedge clk);
            @(posedge clk);
            polls0 = c_polls;
            hi_cnt = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (prod_req) hi_cnt++;
            end
            chk(hi_cnt == 0, "R10 no producer request while run low", hi_cnt, 0);
            chk(c_polls > polls0, "R10 consumer keeps polling", c_polls, polls0 + 1);
            chk(exp_q.size() == 0, "R8 nothing pending while idle", exp_q.size(), 0);
            @(posedge clk); #1;
            run = 1;
        end

        set_mode(1, 2);
        wait_batches(batches + 2);
        set_mode(0, 0);
        wait_batches(batches + 2);

        begin
            int rel0;
            @(posedge clk); #1;
            run = 0;
            rel0 = releases;
            while (releases == rel0) @(posedge clk);
            repeat (30) @(posedge clk);
            @(negedge clk);
            chk(exp_q.size() == 0, "R8 all words delivered", exp_q.size(), 0);
            chk(delivered == batches * LEN, "R7 word count", delivered, batches * LEN);
            chk(releases == batches, "R5 releases match batches", releases, batches);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired batches=%0d", batches);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule